// File: doc/BRIEF.md
# PLL Feedback Divider Setting Calculator

This block turns a requested output frequency and a reference frequency into the two settings a fractional-feedback PLL needs. One setting is a power-of-two post-divider exponent `k`. The other is the feedback word `pcw`, a fixed-point ratio with `INT_W` integer bits and `PCW_W - INT_W` fractional bits. A request is made with a one-cycle `start_i` pulse. The block returns a one-cycle `done_o` pulse, and the results stay on the outputs until the next request.

When a request is accepted, the block latches the target, the reference, the VCO ceiling and the VCO floor. It then works through a small state machine:

- `ST_IDLE` goes to `ST_PREP` on start. Start is ignored in every other state.
- `ST_PREP` clamps the target to the ceiling and replaces a zero floor with the default floor. A zero reference returns at once to `ST_IDLE` with an error. Otherwise the machine moves to `ST_SEARCH`.
- `ST_SEARCH` tests one exponent per cycle, starting at 0. When the scaled target reaches the floor, or when the exponent reaches its cap, the machine moves to `ST_LAUNCH`.
- `ST_LAUNCH` starts a restoring divider and moves to `ST_DIVIDE`.
- `ST_DIVIDE` waits for the quotient, publishes the result and returns to `ST_IDLE`.

Top module: `pll_divset_calc`

## Requirements
- R1: A target above `vco_max_i` is replaced by `vco_max_i` before any other step.
- R2: When `vco_min_i` is zero, the floor used is 1,000,000,000.
- R3: `exp_o` is the smallest k in 0..4 with target·2^k ≥ floor, or 4 when no such k exists.
- R4: `pcw_o` = floor((target·2^k·2^(PCW_W−INT_W)) / reference), computed with 64-bit intermediates and keeping the low 32 bits of the quotient. With the defaults PCW_W=22 and INT_W=7 there are 15 fractional bits.
- R5: A zero reference gives `err_o`=1, `pcw_o`=0 and `exp_o`=0 at `done_o`. Any other reference gives `err_o`=0.
- R6: `busy_o` rises only in the cycle after an accepted `start_i`. A `start_i` while busy is ignored. `done_o` is a one-cycle pulse in the first cycle with `busy_o` low.
- R7: During reset, `busy_o`, `done_o`, `err_o`, `pcw_o` and `exp_o` are all 0.
- R8: While the block is idle and no start arrives, `pcw_o`, `exp_o` and `err_o` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| target_i | input | FREQ_W | Requested output frequency in Hz |
| ref_i | input | FREQ_W | Reference frequency in Hz |
| vco_max_i | input | FREQ_W | VCO ceiling used to clamp the target |
| vco_min_i | input | FREQ_W | VCO floor; zero selects the default |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| err_o | output | 1 | The last request had a zero reference |
| pcw_o | output | FREQ_W | Feedback word |
| exp_o | output | EXP_W | Post-divider exponent |

## Verification
The bench sweeps targets one below, at and one above each boundary floor/2^k. This catches a design that compares with `>` instead of `≥`, or that stops the search one step early or late. Targets above the ceiling catch a missing clamp, which would produce an oversized word. A reference of 1 forces the quotient past 32 bits, so a design that saturates instead of truncating produces wrong words. A zero floor catches a design that fails to substitute the default. A second start sent in the middle of a division would corrupt the result in a design that does not ignore it. A zero reference would hang, or return a stale word, in a design without the error path.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SEARCH,
        ST_LAUNCH,
        ST_DIVIDE
    } pdc_state_e;

endpackage

// File: rtl/pdc_scale.sv
// Scales the target by 2^k; reports whether the floor is reached and
// forms the fixed-point dividend for the feedback word.
module pdc_scale #(
    parameter int FREQ_W = 32,
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 15
) (
    input  logic [FREQ_W-1:0]   tgt_i,
    input  logic [FREQ_W-1:0]   vmin_i,
    input  logic [EXP_W-1:0]    exp_i,
    output logic                reached_o,
    output logic [2*FREQ_W-1:0] dividend_o
);
    localparam int DW = 2 * FREQ_W;

    logic [DW-1:0] scaled;

    assign scaled    = {{FREQ_W{1'b0}}, tgt_i} << exp_i;
    assign reached_o = (scaled >= {{FREQ_W{1'b0}}, vmin_i});

    generate
        if (FRAC_W == 0) begin : g_int_only
            assign dividend_o = scaled;
        end else begin : g_frac
            assign dividend_o = scaled << FRAC_W;
        end
    endgenerate

endmodule

// File: rtl/pdc_restoring_div.sv
// Restoring divider, one quotient bit per cycle, low Q_W quotient bits kept.
module pdc_restoring_div #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32,
    parameter int Q_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             valid_o,
    output logic [Q_W-1:0]   quot_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVS_W-1:0] rem_q;
    logic [Q_W-1:0]   quot_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [DVS_W:0]   trial;
    logic [DVS_W-1:0] diff;
    logic             fits;

    assign trial = {rem_q, dvd_q[DVD_W-1]};
    assign fits  = (trial >= {1'b0, dvs_q});
    assign diff  = trial[DVS_W-1:0] - dvs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q   <= '0;
            dvs_q   <= '0;
            rem_q   <= '0;
            quot_q  <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start_i) begin
                dvd_q  <= dividend_i;
                dvs_q  <= divisor_i;
                rem_q  <= '0;
                quot_q <= '0;
                cnt_q  <= CNT_W'(DVD_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                dvd_q  <= dvd_q << 1;
                rem_q  <= fits ? diff : trial[DVS_W-1:0];
                quot_q <= {quot_q[Q_W-2:0], fits};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q   <= 1'b0;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quot_q;

endmodule

// File: rtl/pll_divset_calc.sv
module pll_divset_calc
    import pdc_pkg::*;
#(
    parameter int FREQ_W      = 32,
    parameter int PCW_W       = 22,
    parameter int INT_W       = 7,
    parameter int MAX_EXP     = 4,
    parameter int unsigned DEF_VCO_MIN = 1_000_000_000,
    localparam int EXP_W      = $clog2(MAX_EXP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] target_i,
    input  logic [FREQ_W-1:0] ref_i,
    input  logic [FREQ_W-1:0] vco_max_i,
    input  logic [FREQ_W-1:0] vco_min_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [FREQ_W-1:0] pcw_o,
    output logic [EXP_W-1:0]  exp_o
);
    localparam int FRAC_W = (PCW_W > INT_W) ? (PCW_W - INT_W) : 0;
    localparam int DVD_W  = 2 * FREQ_W;

    pdc_state_e state_q, state_d;

    logic [FREQ_W-1:0] tgt_q, ref_q, vmax_q, vmin_q;
    logic [EXP_W-1:0]  k_q;
    logic              reached;
    logic [DVD_W-1:0]  dividend;
    logic              div_start;
    logic              div_valid;
    logic [FREQ_W-1:0] div_quot;
    logic              search_end;

    pdc_scale #(
        .FREQ_W (FREQ_W),
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) scale_i (
        .tgt_i      (tgt_q),
        .vmin_i     (vmin_q),
        .exp_i      (k_q),
        .reached_o  (reached),
        .dividend_o (dividend)
    );

    pdc_restoring_div #(
        .DVD_W (DVD_W),
        .DVS_W (FREQ_W),
        .Q_W   (FREQ_W)
    ) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (dividend),
        .divisor_i  (ref_q),
        .valid_o    (div_valid),
        .quot_o     (div_quot)
    );

    assign search_end = reached || (k_q == EXP_W'(MAX_EXP));
    assign div_start  = (state_q == ST_LAUNCH);
    assign busy_o     = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_PREP;
            ST_PREP:   state_d = (ref_q == '0) ? ST_IDLE : ST_SEARCH;
            ST_SEARCH: if (search_end) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            ref_q  <= '0;
            vmax_q <= '0;
            vmin_q <= '0;
            k_q    <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            pcw_o  <= '0;
            exp_o  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tgt_q  <= target_i;
                        ref_q  <= ref_i;
                        vmax_q <= vco_max_i;
                        vmin_q <= vco_min_i;
                    end
                end
                ST_PREP: begin
                    k_q <= '0;
                    if (tgt_q > vmax_q) tgt_q <= vmax_q;
                    if (vmin_q == '0)   vmin_q <= FREQ_W'(DEF_VCO_MIN);
                    if (ref_q == '0) begin
                        err_o  <= 1'b1;
                        pcw_o  <= '0;
                        exp_o  <= '0;
                        done_o <= 1'b1;
                    end
                end
                ST_SEARCH: begin
                    if (!search_end) k_q <= k_q + 1'b1;
                end
                ST_LAUNCH: begin
                end
                ST_DIVIDE: begin
                    if (div_valid) begin
                        err_o  <= 1'b0;
                        pcw_o  <= div_quot;
                        exp_o  <= k_q;
                        done_o <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/pll_divset_calc_chk.sv
module pll_divset_calc_chk #(
    parameter int FREQ_W  = 32,
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [FREQ_W-1:0] pcw_o,
    input logic [EXP_W-1:0]  exp_o
);

    AST_EXP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (exp_o <= EXP_W'(MAX_EXP))); // R3

    AST_ERR_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (pcw_o == '0 && exp_o == '0)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R6

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pcw_o) && $stable(exp_o) && $stable(err_o))); // R8

endmodule

bind pll_divset_calc pll_divset_calc_chk #(
    .FREQ_W  (FREQ_W),
    .EXP_W   (EXP_W),
    .MAX_EXP (MAX_EXP)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .pcw_o   (pcw_o),
    .exp_o   (exp_o)
);

// File: tb/pll_divset_calc_tb_top.sv
`timescale 1ns/1ps
module pll_divset_calc_tb_top;

    localparam int FRAC = 15;   // PCW_W 22 - INT_W 7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] target_i = '0, ref_i = '0, vco_max_i = '0, vco_min_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] pcw_o;
    logic [2:0]  exp_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pll_divset_calc dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .target_i(target_i), .ref_i(ref_i),
        .vco_max_i(vco_max_i), .vco_min_i(vco_min_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .pcw_o(pcw_o), .exp_o(exp_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic model(input logic [31:0] t, r, mx, mn,
                         output logic [31:0] e_pcw, output logic [2:0] e_k, output logic e_err);
        logic [31:0] tc, fl;
        logic [63:0] q;
        int k;
        tc = (t > mx) ? mx : t;
        fl = (mn == 0) ? 32'd1_000_000_000 : mn;
        k = 0;
        while (k < 4 && ((64'(tc) << k) < 64'(fl))) k++;
        if (r == 0) begin
            e_pcw = 0; e_k = 0; e_err = 1'b1;
        end else begin
            q = ((64'(tc) << k) << FRAC) / 64'(r);
            e_pcw = q[31:0]; e_k = 3'(k); e_err = 1'b0;
        end
    endtask

    task automatic run_op(input logic [31:0] t, r, mx, mn, input bit poke);
        logic [31:0] e_pcw;
        logic [2:0]  e_k;
        logic        e_err;
        int cyc;
        string tag_p, tag_k;
        model(t, r, mx, mn, e_pcw, e_k, e_err);
        tag_p = (t > mx) ? "R1" : ((mn == 0) ? "R2" : "R4");
        tag_k = (mn == 0) ? "R2" : "R3";
        @(negedge clk);
        target_i = t; ref_i = r; vco_max_i = mx; vco_min_i = mn; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 busy after start", 64'(busy_o), 64'd1);
        if (poke) begin
            repeat (10) @(negedge clk);
            target_i = ~t; ref_i = r + 32'd3; start_i = 1'b1;   // must be ignored (R6)
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) begin
            check("R6 done timeout", 64'd0, 64'd1);
        end else begin
            check(poke ? "R6 start ignored pcw" : tag_p, 64'(pcw_o), 64'(e_pcw));
            check(tag_k, 64'(exp_o), 64'(e_k));
            check("R5 err", 64'(err_o), 64'(e_err));
            check("R6 busy low at done", 64'(busy_o), 64'd0);
            @(negedge clk);
            check("R6 done single pulse", 64'(done_o), 64'd0);
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] refs [6];
        logic [31:0] mins [2];
        logic [31:0] maxs [2];
        logic [31:0] hold_pcw;
        refs[0] = 32'd26_000_000; refs[1] = 32'd25_000_000; refs[2] = 32'd1;
        refs[3] = 32'd7;          refs[4] = 32'hFFFF_FFFF;  refs[5] = 32'd0;
        mins[0] = 32'd0;          mins[1] = 32'd700_000_000;
        maxs[0] = 32'd3_800_000_000; maxs[1] = 32'd2_000_000_000;

        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 busy", 64'(busy_o), 0);
        check("R7 done", 64'(done_o), 0);
        check("R7 err", 64'(err_o), 0);
        check("R7 pcw", 64'(pcw_o), 0);
        check("R7 exp", 64'(exp_o), 0);
        rst_n = 1'b1;

        for (int ri = 0; ri < 6; ri++) begin
            for (int mi = 0; mi < 2; mi++) begin
                for (int xi = 0; xi < 2; xi++) begin
                    logic [31:0] fl;
                    fl = (mins[mi] == 0) ? 32'd1_000_000_000 : mins[mi];
                    for (int k = 0; k < 6; k++) begin
                        for (int d = -1; d <= 1; d++) begin
                            run_op((fl >> k) + 32'(d), refs[ri], maxs[xi], mins[mi], 1'b0);
                        end
                    end
                    run_op(32'd0, refs[ri], maxs[xi], mins[mi], 1'b0);
                    run_op(maxs[xi], refs[ri], maxs[xi], mins[mi], 1'b0);
                    run_op(maxs[xi] + 32'd1, refs[ri], maxs[xi], mins[mi], 1'b0);   // R1
                    run_op(32'hFFFF_FFFF, refs[ri], maxs[xi], mins[mi], 1'b0);      // R1
                end
            end
        end

        for (int n = 0; n < 300; n++) begin
            logic [31:0] r, mn;
            r  = (n % 3 == 0) ? ($urandom() % 32'd200) + 32'd1 : ($urandom() % 32'd60_000_000) + 32'd1;
            mn = (n % 2 == 0) ? 32'd0 : $urandom() % 32'd2_000_000_000;
            run_op($urandom(), r, 32'd1_000_000_000 + ($urandom() % 32'd3_000_000_000), mn, 1'b0);
        end

        // R6: a second start during the division is ignored
        run_op(32'd1_500_000_000, 32'd26_000_000, 32'd3_800_000_000, 32'd0, 1'b1);

        // R8: idle input changes leave the results alone
        hold_pcw = pcw_o;
        @(negedge clk);
        target_i = 32'd12345; ref_i = 32'd0; vco_min_i = 32'd5;
        repeat (6) @(negedge clk);
        check("R8 pcw held", 64'(pcw_o), 64'(hold_pcw));
        check("R8 err held", 64'(err_o), 64'd0);
        check("R8 busy stays low", 64'(busy_o), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule